// File: doc/BRIEF.md
# Float32 Power-of-Two Scale Unit

This block multiplies one IEEE-754 binary32 operand `op_a` by two raised to the floor of a second binary32 operand `op_b`. The scale operand is itself a float: it is floored to an integer exponent, clamped to a bounded range, and added to the exponent of `op_a`. A subnormal `op_a` is normalized first. Results that leave the normal range are saturated according to the selected rounding mode, or are rounded into the subnormal range.

The unit takes a two-bit rounding mode, a flag that reads denormal inputs as zero, and a flag that flushes tiny results to zero. With each result it returns a five-bit exception vector. That vector describes only the operation that produced it; any accumulation of flags happens outside the block. An optional output register, chosen by parameter, gives one cycle of latency with a valid bit alongside the result.

Top module: `fp_pow2_scale`

## Requirements
- R1: For finite nonzero `op_a` and finite `op_b` whose scaled result lies in the normal range, `result` equals `op_a` times 2^floor(`op_b`) exactly, and `flags` is zero.
- R2: The scale is floor(`op_b`), the largest integer not greater than `op_b`. A negative non-integer such as -0.5 gives -1, -2.5 gives -3, -0.0 gives 0, and a negative subnormal `op_b` read without DAZ gives -1.
- R3: When the biased result exponent reaches 255, flags bit 2 (overflow) and bit 4 (precision) are set. The result is infinity for mode 00 (nearest-even), for mode 10 (toward +inf) with a positive sign, and for mode 01 (toward -inf) with a negative sign. In every other case it is the largest finite magnitude with the sign of `op_a`. Mode 11 is toward zero.
- R4: A result below the normal range is shifted into the subnormal range and rounded by the mode. A result that is tiny before rounding and inexact sets bit 3 (underflow) and bit 4 (precision). An exact subnormal result sets no flag.
- R5: With `ftz` set, a result that is tiny before rounding becomes a zero with the sign of `op_a`, and bits 3 and 4 are set.
- R6: With `daz` set, a subnormal `op_a` or `op_b` is read as a zero of the same sign, and bit 1 (denormal) stays clear.
- R7: Bit 1 (denormal) is set exactly when `op_a` is subnormal and `daz` is clear. A subnormal `op_b` never sets it.
- R8: If `op_a` is NaN, the result is `op_a` with fraction bit 22 forced to 1. Otherwise, if `op_b` is NaN, the result is `op_b` quieted the same way. Bit 0 (invalid) is set when either operand is a signalling NaN, meaning fraction bit 22 is clear.
- R9: Zero `op_a` with `op_b` = +inf, and infinite `op_a` with `op_b` = -inf, return 32'hFFC00000 with bit 0 set. Any other non-NaN `op_a` returns a signed infinity for `op_b` = +inf and a signed zero for `op_b` = -inf, with no overflow, underflow or precision flag.
- R10: A zero or infinite `op_a` paired with a finite `op_b`, or with an infinity that does not conflict with it, is returned unchanged with no flags.
- R11: floor(`op_b`) is clamped to [-512, +512]. A huge positive scale on the smallest subnormal overflows, and a huge negative scale on the largest finite value underflows. The smallest subnormal times 2^276 is exactly 2^127, and times 2^277 overflows.
- R12: With the output register enabled, `out_valid` goes high one cycle after `in_valid`, carrying that operation's result and flags. Reset clears `out_valid`, `result` and `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | Value to be scaled (binary32) |
| op_b | input | 32 | Scale operand (binary32), floored to an integer |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| daz | input | 1 | Read subnormal inputs as zero |
| ftz | input | 1 | Flush tiny results to zero |
| out_valid | output | 1 | Result and flags valid |
| result | output | 32 | Scaled value (binary32) |
| flags | output | 5 | [0] invalid, [1] denormal, [2] overflow, [3] underflow, [4] precision |

## Verification
The bench builds the block with its defaults: 8-bit exponent, 23-bit fraction, scale clamp of 512, and the output register enabled. The registered stage brings the one-cycle valid latency and the reset state of the outputs within reach. The 512 clamp is wide enough that scales of 276 and 277 applied to the smallest subnormal land exactly on either side of overflow, while scales of ±1e30 exercise saturation in both directions.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_DOWN = 2'b01,
      RND_UP   = 2'b10,
      RND_ZERO = 2'b11
   } rnd_e;

   localparam int FLG_INV = 0;
   localparam int FLG_DEN = 1;
   localparam int FLG_OVF = 2;
   localparam int FLG_UNF = 3;
   localparam int FLG_PRC = 4;
   localparam int FLG_W   = 5;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_inf;
      logic is_zero;   // true zero, or subnormal read as zero
      logic is_sub;    // raw subnormal encoding
   } fcls_t;

endpackage

// File: rtl/fps_classify.sv
`timescale 1ns/1ps
module fps_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] x,
   input  logic                  daz,
   output fps_pkg::fcls_t        cls
);
   localparam int W = EXP_W + FRAC_W + 1;

   logic exp_ones, exp_zero, frac_zero;

   always_comb begin
      exp_ones    = &x[W-2:FRAC_W];
      exp_zero    = ~|x[W-2:FRAC_W];
      frac_zero   = ~|x[FRAC_W-1:0];
      cls.is_nan  = exp_ones & ~frac_zero;
      cls.is_snan = exp_ones & ~frac_zero & ~x[FRAC_W-1];
      cls.is_inf  = exp_ones & frac_zero;
      cls.is_sub  = exp_zero & ~frac_zero;
      cls.is_zero = exp_zero & (frac_zero | daz);
   end
endmodule

// File: rtl/fps_normalize.sv
`timescale 1ns/1ps
module fps_normalize #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W-1:0]  mag,
   output logic [FRAC_W:0]          sig,
   output logic signed [EXP_W+1:0]  e
);
   localparam int EW = EXP_W + 2;

   logic [FRAC_W:0] raw;
   int              lz;
   logic            found;

   always_comb begin
      raw   = {1'b0, mag[FRAC_W-1:0]};
      lz    = 0;
      found = 1'b0;
      for (int i = FRAC_W; i >= 0; i--) begin
         if (!found && raw[i]) begin
            lz    = FRAC_W - i;
            found = 1'b1;
         end
      end
      if (|mag[EXP_W+FRAC_W-1:FRAC_W]) begin
         sig = {1'b1, mag[FRAC_W-1:0]};
         e   = EW'(int'(mag[EXP_W+FRAC_W-1:FRAC_W]));
      end else begin
         sig = raw << lz;
         e   = EW'(1 - lz);
      end
   end
endmodule

// File: rtl/fps_floor.sv
`timescale 1ns/1ps
module fps_floor #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int CLAMP  = 512,
   parameter int KW     = 11
) (
   input  logic [EXP_W+FRAC_W:0]  x,
   input  fps_pkg::fcls_t         cls,
   output logic signed [KW-1:0]   k
);
   localparam int W    = EXP_W + FRAC_W + 1;
   localparam int BIAS = 2**(EXP_W-1) - 1;
   localparam int LIM  = KW - 1;
   localparam logic [FRAC_W:0] ONE = 1;

   logic            neg, fnz;
   logic [FRAC_W:0] sig, ip, lowm;
   int              uei, sh, mi, kv;

   always_comb begin
      neg  = x[W-1];
      sig  = {1'b1, x[FRAC_W-1:0]};
      uei  = int'(x[W-2:FRAC_W]) - BIAS;
      sh   = 0;
      ip   = '0;
      lowm = '0;
      fnz  = 1'b0;
      mi   = 0;
      if (cls.is_zero) begin
         kv = 0;
      end else if (cls.is_sub || uei < 0) begin
         kv = neg ? -1 : 0;
      end else if (uei >= LIM) begin
         kv = neg ? -CLAMP : CLAMP;
      end else begin
         sh   = FRAC_W - uei;
         ip   = sig >> sh;
         lowm = (ONE << sh) - ONE;
         fnz  = |(sig & lowm);
         mi   = int'(ip);
         kv   = neg ? -(mi + (fnz ? 1 : 0)) : mi;
      end
      if (kv > CLAMP)  kv = CLAMP;
      if (kv < -CLAMP) kv = -CLAMP;
      k = KW'(kv);
   end
endmodule

// File: rtl/fps_scale_round.sv
`timescale 1ns/1ps
module fps_scale_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int KW     = 11
) (
   input  logic                     sgn,
   input  logic [FRAC_W:0]          sig,
   input  logic signed [EXP_W+1:0]  e,
   input  logic signed [KW-1:0]     k,
   input  logic [1:0]               rnd,
   input  logic                     ftz,
   output logic [EXP_W+FRAC_W-1:0]  mag,
   output logic                     ovf,
   output logic                     unf,
   output logic                     inx
);
   localparam int P    = FRAC_W + 1;
   localparam int MW   = EXP_W + FRAC_W;
   localparam int EMAX = 2**EXP_W - 1;
   localparam logic [MW-1:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   localparam logic [MW-1:0] MAX_MAG = {EXP_W'(EMAX-1), {FRAC_W{1'b1}}};

   int               rei, sh;
   logic [2*P+1:0]   wide;
   logic [P-1:0]     upper;
   logic             rb, st, inc, to_inf;

   always_comb begin
      rei    = int'(e) + int'(k);
      sh     = 0;
      wide   = '0;
      upper  = '0;
      rb     = 1'b0;
      st     = 1'b0;
      inc    = 1'b0;
      ovf    = 1'b0;
      unf    = 1'b0;
      inx    = 1'b0;
      case (fps_pkg::rnd_e'(rnd))
         fps_pkg::RND_NEAR: to_inf = 1'b1;
         fps_pkg::RND_DOWN: to_inf = sgn;
         fps_pkg::RND_UP:   to_inf = ~sgn;
         default:           to_inf = 1'b0;
      endcase
      if (rei >= EMAX) begin
         ovf = 1'b1;
         inx = 1'b1;
         mag = to_inf ? INF_MAG : MAX_MAG;
      end else if (rei >= 1) begin
         mag = {EXP_W'(rei), sig[FRAC_W-1:0]};
      end else if (ftz) begin
         unf = 1'b1;
         inx = 1'b1;
         mag = '0;
      end else begin
         sh = 1 - rei;
         if (sh > P + 1) sh = P + 1;
         wide  = {sig, {(P+2){1'b0}}} >> sh;
         upper = wide[2*P+1:P+2];
         rb    = wide[P+1];
         st    = |wide[P:0];
         case (fps_pkg::rnd_e'(rnd))
            fps_pkg::RND_NEAR: inc = rb & (st | upper[0]);
            fps_pkg::RND_DOWN: inc = (rb | st) & sgn;
            fps_pkg::RND_UP:   inc = (rb | st) & ~sgn;
            default:           inc = 1'b0;
         endcase
         inx = rb | st;
         unf = rb | st;
         mag = {{(EXP_W-1){1'b0}}, upper} + {{(MW-1){1'b0}}, inc};
      end
   end
endmodule

// File: rtl/fp_pow2_scale.sv
`timescale 1ns/1ps
module fp_pow2_scale #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int CLAMP   = 512,
   parameter int REG_OUT = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [EXP_W+FRAC_W:0]      op_a,
   input  logic [EXP_W+FRAC_W:0]      op_b,
   input  logic [1:0]                 rnd_mode,
   input  logic                       daz,
   input  logic                       ftz,
   output logic                       out_valid,
   output logic [EXP_W+FRAC_W:0]      result,
   output logic [fps_pkg::FLG_W-1:0]  flags
);
   import fps_pkg::*;

   localparam int W    = EXP_W + FRAC_W + 1;
   localparam int BIAS = 2**(EXP_W-1) - 1;
   localparam int KW   = $clog2(CLAMP) + 2;
   localparam logic [W-1:0] DNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [W-1:0] QBIT = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("REG_OUT must be 0 or 1");
   end
   if (CLAMP < 2*BIAS + FRAC_W + 2) begin : g_bad_clamp
      $error("CLAMP too small to reach every overflow and underflow");
   end
   if (FRAC_W < KW - 1 || FRAC_W > 30) begin : g_bad_frac
      $error("FRAC_W out of supported range for this CLAMP");
   end
   if (EXP_W < 3) begin : g_bad_exp
      $error("EXP_W too small");
   end

   logic [1:0][W-1:0] ops;
   fcls_t             cls [2];

   assign ops = {op_b, op_a};

   for (genvar g = 0; g < 2; g++) begin : g_cls
      fps_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .x   (ops[g]),
         .daz (daz),
         .cls (cls[g])
      );
   end

   logic signed [KW-1:0]     k;
   logic [FRAC_W:0]          a_sig;
   logic signed [EXP_W+1:0]  a_e;
   logic [W-2:0]             s_mag;
   logic                     s_ovf, s_unf, s_inx;

   fps_floor #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CLAMP(CLAMP), .KW(KW)) u_floor (
      .x   (op_b),
      .cls (cls[1]),
      .k   (k)
   );

   fps_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
      .mag (op_a[W-2:0]),
      .sig (a_sig),
      .e   (a_e)
   );

   fps_scale_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .KW(KW)) u_round (
      .sgn (op_a[W-1]),
      .sig (a_sig),
      .e   (a_e),
      .k   (k),
      .rnd (rnd_mode),
      .ftz (ftz),
      .mag (s_mag),
      .ovf (s_ovf),
      .unf (s_unf),
      .inx (s_inx)
   );

   logic [W-1:0]     c_res;
   logic [FLG_W-1:0] c_flg;

   always_comb begin
      c_flg          = '0;
      c_flg[FLG_DEN] = cls[0].is_sub & ~daz;
      if (cls[0].is_nan || cls[1].is_nan) begin
         c_res          = cls[0].is_nan ? (op_a | QBIT) : (op_b | QBIT);
         c_flg[FLG_INV] = cls[0].is_snan | cls[1].is_snan;
      end else if (cls[1].is_inf) begin
         if (!op_b[W-1]) begin
            if (cls[0].is_zero) begin
               c_res          = DNAN;
               c_flg[FLG_INV] = 1'b1;
            end else begin
               c_res = {op_a[W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
         end else begin
            if (cls[0].is_inf) begin
               c_res          = DNAN;
               c_flg[FLG_INV] = 1'b1;
            end else begin
               c_res = {op_a[W-1], {(W-1){1'b0}}};
            end
         end
      end else if (cls[0].is_zero) begin
         c_res = {op_a[W-1], {(W-1){1'b0}}};
      end else if (cls[0].is_inf) begin
         c_res = op_a;
      end else begin
         c_res          = {op_a[W-1], s_mag};
         c_flg[FLG_OVF] = s_ovf;
         c_flg[FLG_UNF] = s_unf;
         c_flg[FLG_PRC] = s_inx;
      end
   end

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= c_res;
               flags  <= c_flg;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = c_res;
      assign flags     = c_flg;
   end
endmodule

// File: rtl/fp_pow2_scale_chk.sv
`timescale 1ns/1ps
module fp_pow2_scale_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int LAT    = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [EXP_W+FRAC_W-1:0]   a_mag,
   input logic                      daz,
   input logic                      ftz,
   input logic                      out_valid,
   input logic [EXP_W+FRAC_W:0]     result,
   input logic [fps_pkg::FLG_W-1:0] flags
);
   import fps_pkg::*;

   localparam int W = EXP_W + FRAC_W + 1;
   localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   localparam logic [W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

   logic [W-2:0] cap_a;
   logic         cap_daz, cap_ftz;
   logic         res_nan;

   assign res_nan = (&result[W-2:FRAC_W]) & (|result[FRAC_W-1:0]);

   if (LAT == 1) begin : g_lat
      always_ff @(posedge clk) begin
         if (in_valid) begin
            cap_a   <= a_mag;
            cap_daz <= daz;
            cap_ftz <= ftz;
         end
      end

      p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end else begin : g_nolat
      assign cap_a   = a_mag;
      assign cap_daz = daz;
      assign cap_ftz = ftz;
   end

   p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flags[FLG_OVF] |->
         flags[FLG_PRC] && (result[W-2:0] == INF_MAG || result[W-2:0] == MAX_MAG));

   p_ovf_unf_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(flags[FLG_OVF] && flags[FLG_UNF]));

   p_unf_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flags[FLG_UNF] |->
         flags[FLG_PRC] && (result[W-2:FRAC_W] <= EXP_W'(1)));

   p_ftz_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cap_ftz && flags[FLG_UNF] |-> result[W-2:0] == '0);

   p_daz_noden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cap_daz |-> !flags[FLG_DEN]);

   p_den_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flags[FLG_DEN] |->
         cap_a[W-2:FRAC_W] == '0 && cap_a[FRAC_W-1:0] != '0 && !cap_daz);

   p_inv_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flags[FLG_INV] |-> res_nan);

   p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && res_nan |-> result[FRAC_W-1]);
endmodule

bind fp_pow2_scale fp_pow2_scale_chk #(
   .EXP_W (EXP_W),
   .FRAC_W(FRAC_W),
   .LAT   (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .a_mag    (op_a[EXP_W+FRAC_W-1:0]),
   .daz      (daz),
   .ftz      (ftz),
   .out_valid(out_valid),
   .result   (result),
   .flags    (flags)
);

// File: tb/fp_pow2_scale_tb.sv
`timescale 1ns/1ps
module fp_pow2_scale_tb;

   localparam logic [4:0] F_INV = 5'h01;
   localparam logic [4:0] F_DEN = 5'h02;
   localparam logic [4:0] F_OVF = 5'h04;
   localparam logic [4:0] F_UNF = 5'h08;
   localparam logic [4:0] F_PRC = 5'h10;

   localparam logic [1:0] M_NE = 2'b00, M_DN = 2'b01, M_UP = 2'b10, M_TZ = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [1:0]  rnd = '0;
   logic        daz = 1'b0, ftz = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic [4:0]  flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fp_pow2_scale #(.EXP_W(8), .FRAC_W(23), .CLAMP(512), .REG_OUT(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a), .op_b(b),
      .rnd_mode(rnd), .daz(daz), .ftz(ftz),
      .out_valid(out_valid), .result(result), .flags(flags)
   );

   task automatic op(input string tag, input logic [31:0] ia, input logic [31:0] ib,
                     input logic [1:0] m, input logic d, input logic f,
                     input logic [31:0] er, input logic [4:0] ef);
      @(negedge clk);
      a = ia; b = ib; rnd = m; daz = d; ftz = f; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      n_checks++;
      if (out_valid !== 1'b1 || result !== er || flags !== ef) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h got valid %b result %h flags %h, expected valid 1 result %h flags %h",
                  tag, ia, ib, out_valid, result, flags, er, ef);
      end
   endtask

   task automatic t_r12_reset;
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || result !== 32'h0 || flags !== 5'h0) begin
         n_fail++;
         $display("FAIL R12 reset: got valid %b result %h flags %h, expected 0 0 0",
                  out_valid, result, flags);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_r1_basic;
      op("R1", 32'h3FC00000, 32'h40400000, M_NE, 0, 0, 32'h41400000, 5'h0);
      op("R1", 32'hC0400000, 32'h402CCCCD, M_TZ, 0, 0, 32'hC1400000, 5'h0);
      op("R1", 32'h3F800000, 32'hC0400000, M_UP, 0, 0, 32'h3E000000, 5'h0);
   endtask

   task automatic t_r2_floor;
      op("R2", 32'h3F800000, 32'hBF000000, M_NE, 0, 0, 32'h3F000000, 5'h0);
      op("R2", 32'h40800000, 32'hC0200000, M_NE, 0, 0, 32'h3F000000, 5'h0);
      op("R2", 32'h3F800000, 32'h3F000000, M_NE, 0, 0, 32'h3F800000, 5'h0);
      op("R2", 32'h3F800000, 32'h80000000, M_NE, 0, 0, 32'h3F800000, 5'h0);
      op("R2", 32'h3F800000, 32'h80000001, M_NE, 0, 0, 32'h3F000000, 5'h0);
   endtask

   task automatic t_r3_overflow;
      op("R3", 32'h7F7FFFFF, 32'h3F800000, M_NE, 0, 0, 32'h7F800000, F_OVF | F_PRC);
      op("R3", 32'h7F7FFFFF, 32'h3F800000, M_TZ, 0, 0, 32'h7F7FFFFF, F_OVF | F_PRC);
      op("R3", 32'h7F7FFFFF, 32'h3F800000, M_DN, 0, 0, 32'h7F7FFFFF, F_OVF | F_PRC);
      op("R3", 32'h7F7FFFFF, 32'h3F800000, M_UP, 0, 0, 32'h7F800000, F_OVF | F_PRC);
      op("R3", 32'hFF7FFFFF, 32'h3F800000, M_DN, 0, 0, 32'hFF800000, F_OVF | F_PRC);
      op("R3", 32'hFF7FFFFF, 32'h3F800000, M_UP, 0, 0, 32'hFF7FFFFF, F_OVF | F_PRC);
   endtask

   task automatic t_r4_subnormal;
      op("R4", 32'h3F800000, 32'hC2FE0000, M_NE, 0, 0, 32'h00400000, 5'h0);
      op("R4", 32'h3FC00000, 32'hC3150000, M_NE, 0, 0, 32'h00000002, F_UNF | F_PRC);
      op("R4", 32'h3FC00000, 32'hC3150000, M_TZ, 0, 0, 32'h00000001, F_UNF | F_PRC);
      op("R4", 32'h3FC00000, 32'hC3150000, M_DN, 0, 0, 32'h00000001, F_UNF | F_PRC);
      op("R4", 32'h3FA00000, 32'hC3150000, M_NE, 0, 0, 32'h00000001, F_UNF | F_PRC);
      op("R4", 32'h3FA00000, 32'hC3150000, M_UP, 0, 0, 32'h00000002, F_UNF | F_PRC);
      op("R4", 32'hBFA00000, 32'hC3150000, M_DN, 0, 0, 32'h80000002, F_UNF | F_PRC);
      op("R4", 32'hBFA00000, 32'hC3150000, M_UP, 0, 0, 32'h80000001, F_UNF | F_PRC);
      op("R4", 32'h3F800000, 32'hC3170000, M_NE, 0, 0, 32'h00000000, F_UNF | F_PRC);
      op("R4", 32'h3F800000, 32'hC3170000, M_UP, 0, 0, 32'h00000001, F_UNF | F_PRC);
      op("R4", 32'h3FFFFFFF, 32'hC2FE0000, M_NE, 0, 0, 32'h00800000, F_UNF | F_PRC);
   endtask

   task automatic t_r5_ftz;
      op("R5", 32'h3FC00000, 32'hC3150000, M_UP, 0, 1, 32'h00000000, F_UNF | F_PRC);
      op("R5", 32'hBF800000, 32'hC2FE0000, M_NE, 0, 1, 32'h80000000, F_UNF | F_PRC);
   endtask

   task automatic t_r6_daz;
      op("R6", 32'h00000001, 32'h3F800000, M_NE, 1, 0, 32'h00000000, 5'h0);
      op("R6", 32'h80400000, 32'h3F800000, M_NE, 1, 0, 32'h80000000, 5'h0);
      op("R6", 32'h3F800000, 32'h80000001, M_NE, 1, 0, 32'h3F800000, 5'h0);
   endtask

   task automatic t_r7_denormal;
      op("R7", 32'h00400000, 32'h40000000, M_NE, 0, 0, 32'h01000000, F_DEN);
      op("R7", 32'h3F800000, 32'h00000001, M_NE, 0, 0, 32'h3F800000, 5'h0);
   endtask

   task automatic t_r8_nan;
      op("R8", 32'h7FA00000, 32'h3F800000, M_NE, 0, 0, 32'h7FE00000, F_INV);
      op("R8", 32'h3F800000, 32'hFFC00001, M_NE, 0, 0, 32'hFFC00001, 5'h0);
      op("R8", 32'h7FC00000, 32'h7F800001, M_NE, 0, 0, 32'h7FC00000, F_INV);
   endtask

   task automatic t_r9_inf_scale;
      op("R9", 32'h00000000, 32'h7F800000, M_NE, 0, 0, 32'hFFC00000, F_INV);
      op("R9", 32'h7F800000, 32'hFF800000, M_NE, 0, 0, 32'hFFC00000, F_INV);
      op("R9", 32'hC0000000, 32'h7F800000, M_TZ, 0, 0, 32'hFF800000, 5'h0);
      op("R9", 32'h40400000, 32'hFF800000, M_UP, 0, 0, 32'h00000000, 5'h0);
      op("R9", 32'hC0400000, 32'hFF800000, M_NE, 0, 0, 32'h80000000, 5'h0);
   endtask

   task automatic t_r10_passthru;
      op("R10", 32'h80000000, 32'h42C80000, M_NE, 0, 0, 32'h80000000, 5'h0);
      op("R10", 32'hFF800000, 32'hC0A00000, M_NE, 0, 0, 32'hFF800000, 5'h0);
      op("R10", 32'h7F800000, 32'h7F800000, M_NE, 0, 0, 32'h7F800000, 5'h0);
   endtask

   task automatic t_r11_clamp;
      op("R11", 32'h00000001, 32'h7149F2CA, M_NE, 0, 0, 32'h7F800000, F_DEN | F_OVF | F_PRC);
      op("R11", 32'h7F7FFFFF, 32'hF149F2CA, M_NE, 0, 0, 32'h00000000, F_UNF | F_PRC);
      op("R11", 32'h7F7FFFFF, 32'hF149F2CA, M_UP, 0, 0, 32'h00000001, F_UNF | F_PRC);
      op("R11", 32'h00000001, 32'h438A0000, M_NE, 0, 0, 32'h7F000000, F_DEN);
      op("R11", 32'h00000001, 32'h438A8000, M_NE, 0, 0, 32'h7F800000, F_DEN | F_OVF | F_PRC);
   endtask

   task automatic t_r12_valid;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R12 idle: got valid %b, expected 0", out_valid);
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      t_r12_reset;
      t_r1_basic;
      t_r2_floor;
      t_r3_overflow;
      t_r4_subnormal;
      t_r5_ftz;
      t_r6_daz;
      t_r7_denormal;
      t_r8_nan;
      t_r9_inf_scale;
      t_r10_passthru;
      t_r11_clamp;
      t_r12_valid;
      done = 1'b1;
      summary;
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion within 5000 cycles");
         summary;
         $finish;
      end
   end
endmodule